// File: doc/BRIEF.md
# Multi-Mode Timer Counter Unit

A timer/counter core that advances on a prescaled count tick and runs in one of three widths or behaviours. In free-running byte mode the low byte counts up and wraps from 0xFF to 0x00. In clear-on-compare byte mode the count returns to zero on the tick taken while it equals a compare register, so the compare value sets the period. In wide mode both bytes form one 16-bit counter that wraps from 0xFFFF to 0x0000.

A host loads the counter or the compare register through a single write port. Two sticky flags record overflow and compare-match events. Each flag stays set until an interrupt-acknowledge strobe clears it. Each flag is gated by its own enable to form an interrupt request. The compare register has no shadow copy, so a new value is used from the next tick on.

Top module: `mode_timer`

## Requirements
- R1: Mode encoding on mode_i: 0 free-running byte, 1 clear-on-compare byte, 2 wide 16-bit, 3 behaves as 0. In free-running byte mode each tick adds one to the low byte, 0xFF is followed by 0x00, and the upper byte of cnt_o reads zero.
- R2: The overflow flag becomes set at the same clock edge at which the count wraps to zero. This holds for a 0xFF to 0x00 wrap in both byte modes and for a 0xFFFF to 0x0000 wrap in wide mode.
- R3: Both flags are sticky. Ticks without events leave them set, and only the matching clear strobe (ovf_clr_i, cmp_clr_i) resets them.
- R4: If a flag's set event and its clear strobe fall in the same cycle, the flag ends set.
- R5: A counter write (wr_cnt_i) loads wr_data_i at any time and counting continues from it. In byte modes only bits 7:0 are loaded and the upper byte becomes zero. A tick in the same cycle as the write is dropped.
- R6: In clear-on-compare mode, a tick taken while the low byte equals the compare register sets the count to zero and sets the compare flag. The zero value is compared again on the next tick, so a compare value of 0 gives a match on every tick.
- R7: A compare write (wr_cmp_i, bits 7:0 of wr_data_i) is used from the next tick. If it is below the current count, the counter runs on to 0xFF, wraps to 0x00 (setting overflow), and then matches at the new value.
- R8: In wide mode the counter wraps from 0xFFFF to 0x0000, and the compare flag is never set.
- R9: ovf_irq_o equals the overflow flag ANDed with ovf_ie_i. cmp_irq_o equals the compare flag ANDed with cmp_ie_i.
- R10: Without a tick or a counter write, the count holds its value.
- R11: In free-running byte mode, a tick taken while the low byte equals the compare register sets the compare flag and does not clear the count.
- R12: After reset the count, the compare register and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| mode_i | input | 2 | Operating mode |
| wr_cnt_i | input | 1 | Load counter from wr_data_i |
| wr_cmp_i | input | 1 | Load compare register from wr_data_i[7:0] |
| wr_data_i | input | 16 | Host write data |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| cmp_clr_i | input | 1 | Compare flag clear strobe |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| cnt_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cmp_irq_o | output | 1 | Compare interrupt request |

## Verification
The hardest case to reach is the missed compare. The compare value must drop below a running count in clear-on-compare mode, and the counter must then take the long way round through 0xFF before it matches. The stimulus gets there in two steps. First it presets the count just above a new compare value through the write port. Then it ticks through the full remaining range, checking that no early match occurs, that overflow appears exactly at the wrap, and that the match comes exactly at the new compare value. Same-cycle collisions between writes, ticks, set events and clear strobes are driven directly from the vector table.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE8  = 2'd0,
    MODE_CMP8   = 2'd1,
    MODE_WIDE16 = 2'd2,
    MODE_ALT8   = 2'd3
  } mode_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_CMP  = 1;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_q); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i |=> flag_q); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import mode_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  mode_e             mode_i,
  input  logic              wr_cnt_i,
  input  logic              wr_cmp_i,
  input  logic [2*BYTE_W-1:0] wr_data_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic              ovf_evt_o,
  output logic              cmp_evt_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] HI_ZERO = '0;
  localparam logic [BYTE_W-1:0] LO_ONE  = BYTE_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] cmp_q;
  logic [BYTE_W-1:0] lo;
  logic              lo_max, full_max, lo_hit, wide;

  assign lo       = cnt_q[BYTE_W-1:0];
  assign lo_max   = &lo;
  assign full_max = &cnt_q;
  assign lo_hit   = (lo == cmp_q);
  assign wide     = (mode_i == MODE_WIDE16);

  always_comb begin
    cnt_d     = cnt_q;
    ovf_evt_o = 1'b0;
    cmp_evt_o = 1'b0;
    if (wr_cnt_i) begin
      // host load wins; tick in this cycle is dropped
      cnt_d = wide ? wr_data_i : {HI_ZERO, wr_data_i[BYTE_W-1:0]};
    end else if (tick_i) begin
      unique case (mode_i)
        MODE_WIDE16: begin
          cnt_d     = cnt_q + CNT_ONE;
          ovf_evt_o = full_max;
        end
        MODE_CMP8: begin
          cmp_evt_o = lo_hit;
          ovf_evt_o = lo_max;
          cnt_d     = lo_hit ? '0 : {HI_ZERO, lo + LO_ONE};
        end
        default: begin
          cmp_evt_o = lo_hit;
          ovf_evt_o = lo_max;
          cnt_d     = {HI_ZERO, lo + LO_ONE};
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_cmp_i) cmp_q <= wr_data_i[BYTE_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_cnt_i |=> $stable(cnt_q)); // R10
  AST_WIDE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i && wide |=> cnt_q == $past(wr_data_i)); // R5
  AST_BYTE_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i || wr_cnt_i) && !wide |=> cnt_q[CNT_W-1:BYTE_W] == '0); // R1
  AST_CMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_cnt_i && mode_i == MODE_CMP8 && lo == cmp_q |=> cnt_q == '0); // R6
  AST_WIDE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_cnt_i && wide && full_max |=> cnt_q == '0); // R8
  AST_WIDE_NO_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide |-> !cmp_evt_o); // R8
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mode_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [1:0]          mode_i,
  input  logic                wr_cnt_i,
  input  logic                wr_cmp_i,
  input  logic [2*BYTE_W-1:0] wr_data_i,
  input  logic                ovf_clr_i,
  input  logic                cmp_clr_i,
  input  logic                ovf_ie_i,
  input  logic                cmp_ie_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                ovf_flag_o,
  output logic                cmp_flag_o,
  output logic                ovf_irq_o,
  output logic                cmp_irq_o
);
  logic                 ovf_evt, cmp_evt;
  logic [NUM_FLAGS-1:0] set_v, clr_v, ie_v, flag_v, irq_v;

  tmr_counter #(.BYTE_W(BYTE_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .mode_i    (mode_e'(mode_i)),
    .wr_cnt_i  (wr_cnt_i),
    .wr_cmp_i  (wr_cmp_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o),
    .ovf_evt_o (ovf_evt),
    .cmp_evt_o (cmp_evt)
  );

  assign set_v[FLAG_OVF] = ovf_evt;
  assign set_v[FLAG_CMP] = cmp_evt;
  assign clr_v[FLAG_OVF] = ovf_clr_i;
  assign clr_v[FLAG_CMP] = cmp_clr_i;
  assign ie_v[FLAG_OVF]  = ovf_ie_i;
  assign ie_v[FLAG_CMP]  = cmp_ie_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .ie_i   (ie_v[g]),
      .flag_o (flag_v[g]),
      .irq_o  (irq_v[g])
    );
  end

  assign ovf_flag_o = flag_v[FLAG_OVF];
  assign cmp_flag_o = flag_v[FLAG_CMP];
  assign ovf_irq_o  = irq_v[FLAG_OVF];
  assign cmp_irq_o  = irq_v[FLAG_CMP];

  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> cnt_o == '0); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_irq_o |-> ovf_flag_o) and (cmp_irq_o |-> cmp_flag_o)); // R9
endmodule

// File: tb/mode_timer_tb.sv
module mode_timer_tb;
  typedef struct packed {
    logic [1:0]  mode;
    logic        wc;
    logic        wp;
    logic [15:0] d;
    logic        tk;
    logic        oc;
    logic        cc;
    logic [15:0] ec;
    logic        eo;
    logic        ef;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b1,16'h0080,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 0 cmp=80
    '{2'd0,1'b1,1'b0,16'h12FD,1'b0,1'b0,1'b0,16'h00FD,1'b0,1'b0}, // 1 R5 byte load
    '{2'd0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h00FE,1'b0,1'b0}, // 2 R1
    '{2'd0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h00FF,1'b0,1'b0}, // 3 R1
    '{2'd0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 4 R2 wrap
    '{2'd0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0001,1'b1,1'b0}, // 5 R3 sticky
    '{2'd0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0001,1'b0,1'b0}, // 6 R3 clear
    '{2'd0,1'b1,1'b0,16'h0010,1'b1,1'b0,1'b0,16'h0010,1'b0,1'b0}, // 7 R5 tick dropped
    '{2'd1,1'b0,1'b1,16'h0012,1'b0,1'b0,1'b0,16'h0010,1'b0,1'b0}, // 8 cmp=12
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0011,1'b0,1'b0}, // 9
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0012,1'b0,1'b0}, // 10
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b1}, // 11 R6 match
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0001,1'b0,1'b1}, // 12 R3
    '{2'd1,1'b1,1'b0,16'h0030,1'b0,1'b0,1'b1,16'h0030,1'b0,1'b0}, // 13 above cmp
    '{2'd1,1'b1,1'b0,16'h00FF,1'b0,1'b0,1'b0,16'h00FF,1'b0,1'b0}, // 14
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 15 R7 wrap
    '{2'd1,1'b1,1'b0,16'h0011,1'b0,1'b0,1'b0,16'h0011,1'b1,1'b0}, // 16
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0012,1'b1,1'b0}, // 17
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b1}, // 18 R6
    '{2'd1,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0000,1'b0,1'b0}, // 19 R3
    '{2'd1,1'b0,1'b1,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 20 cmp=0
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b1}, // 21 R6 every tick
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b1,16'h0000,1'b0,1'b1}, // 22 R4 set wins
    '{2'd2,1'b1,1'b0,16'hFFFE,1'b0,1'b0,1'b0,16'hFFFE,1'b0,1'b1}, // 23 R5 wide load
    '{2'd2,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b1,16'hFFFE,1'b0,1'b0}, // 24
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'hFFFF,1'b0,1'b0}, // 25
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 26 R8 wrap
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0001,1'b1,1'b0}, // 27 R8 no cmp
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0002,1'b0,1'b0}, // 28
    '{2'd2,1'b1,1'b0,16'hFFFF,1'b0,1'b0,1'b0,16'hFFFF,1'b0,1'b0}, // 29
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0}, // 30 R4 ovf
    '{2'd2,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 31 R10 hold
    '{2'd0,1'b0,1'b1,16'h0005,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 32 cmp=5
    '{2'd0,1'b1,1'b0,16'h0005,1'b0,1'b0,1'b0,16'h0005,1'b1,1'b0}, // 33
    '{2'd0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0005,1'b0,1'b0}, // 34
    '{2'd0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0006,1'b0,1'b1}, // 35 R11
    '{2'd3,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0007,1'b0,1'b1}  // 36 R1 mode 3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        wr_cnt_i = 1'b0;
  logic        wr_cmp_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        ovf_clr_i = 1'b0;
  logic        cmp_clr_i = 1'b0;
  logic        ovf_ie_i = 1'b0;
  logic        cmp_ie_i = 1'b0;
  logic [15:0] cnt_o;
  logic        ovf_flag_o, cmp_flag_o, ovf_irq_o, cmp_irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mode_timer u_dut (
    .clk_i, .rst_ni, .tick_i, .mode_i, .wr_cnt_i, .wr_cmp_i, .wr_data_i,
    .ovf_clr_i, .cmp_clr_i, .ovf_ie_i, .cmp_ie_i,
    .cnt_o, .ovf_flag_o, .cmp_flag_o, .ovf_irq_o, .cmp_irq_o
  );

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual {cnt,ovf,cmp}=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    tick_i = 0; wr_cnt_i = 0; wr_cmp_i = 0; ovf_clr_i = 0; cmp_clr_i = 0;
  endtask

  task automatic tick_n(int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R12 reset", {cnt_o, ovf_flag_o, cmp_flag_o}, 18'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      mode_i = VECS[i].mode; wr_cnt_i = VECS[i].wc; wr_cmp_i = VECS[i].wp;
      wr_data_i = VECS[i].d; tick_i = VECS[i].tk;
      ovf_clr_i = VECS[i].oc; cmp_clr_i = VECS[i].cc;
      @(negedge clk_i);
      check($sformatf("vector %0d (R1-R11 table)", i), {cnt_o, ovf_flag_o, cmp_flag_o},
            {VECS[i].ec, VECS[i].eo, VECS[i].ef});
    end
    idle_inputs();

    // R9: irq gating; state after table: ovf=0, cmp=1
    cmp_ie_i = 1; ovf_ie_i = 1; #1;
    check("R9 irq", {16'h0, ovf_irq_o, cmp_irq_o}, {16'h0, 1'b0, 1'b1});
    cmp_ie_i = 0; #1;
    check("R9 irq off", {16'h0, ovf_irq_o, cmp_irq_o}, 18'h0);
    ovf_ie_i = 0;

    // R7: compare lowered below count, long way round
    mode_i = 2'd1; wr_cmp_i = 1; wr_data_i = 16'h0040;
    ovf_clr_i = 1; cmp_clr_i = 1; @(negedge clk_i);
    idle_inputs();
    wr_cnt_i = 1; wr_data_i = 16'h0041; @(negedge clk_i);
    wr_cnt_i = 0;
    tick_n(8'hBE);
    check("R7 before wrap", {cnt_o, ovf_flag_o, cmp_flag_o}, {16'h00FF, 2'b00});
    tick_n(1);
    check("R7 R2 wrap", {cnt_o, ovf_flag_o, cmp_flag_o}, {16'h0000, 2'b10});
    tick_n(8'h40);
    check("R7 at new top", {cnt_o, ovf_flag_o, cmp_flag_o}, {16'h0040, 2'b10});
    tick_n(1);
    check("R7 R6 match", {cnt_o, ovf_flag_o, cmp_flag_o}, {16'h0000, 2'b11});

    // R12: reset mid-run
    tick_i = 1; #2; rst_ni = 0; #1;
    check("R12 async reset", {cnt_o, ovf_flag_o, cmp_flag_o}, 18'h0);
    tick_i = 0;
    @(negedge clk_i); rst_ni = 1;
    mode_i = 2'd1; tick_n(1);
    check("R12 cmp reg zero", {cnt_o, ovf_flag_o, cmp_flag_o}, {16'h0000, 2'b01});

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule